// File: doc/BRIEF.md
# Edge-Kicked Watchdog Timer

This block watches a processor heartbeat line and pulls an active-low flag when the heartbeat stops toggling for longer than a programmed number of clock cycles. Both a rising and a falling transition count as a kick. Each kick starts a fresh countdown. Once the countdown runs out, the flag stays low until the next kick.

The heartbeat line is asynchronous, so it passes through a multi-flop synchroniser before any transitions are detected. A separate valid input marks the heartbeat line as floating. While the line is floating, or while the system reset is active, the timer is held clear and the watchdog is disabled. When the hold is lifted, counting does not resume until a fresh transition is seen.

A supply-good input overrides the timer. While the supply is bad the flag is low. When the supply recovers, the flag returns high in the same cycle, with no minimum low time. Routing the flag back into a reset source is done outside this block.

Top module: `edge_kick_wdt`

## Requirements
- R1: After `rst_n` is released, `wd_flag_n` is 1. With no transition on `wd_in`, it stays 1 for any length of time.
- R2: Suppose `wd_in` changes and the new value is first sampled at clock edge n, with no further change. Then `wd_flag_n` is still 1 after edge n+TIMEOUT_CYCLES+1 and goes to 0 after edge n+TIMEOUT_CYCLES+2. This delay is two synchroniser cycles, one cycle for transition detection, and TIMEOUT_CYCLES of counting.
- R3: Each further transition on `wd_in` restarts the full countdown. Transitions spaced closer than the timeout keep `wd_flag_n` at 1.
- R4: Once `wd_flag_n` has gone to 0, it stays 0 until a transition on `wd_in`. A transition first sampled at edge n returns it to 1 after edge n+2 and starts a new countdown.
- R5: While `sys_reset_active` is 1, the timer is cleared after each clock edge and does not count, so `wd_flag_n` is 1 while supply is good. After release, no countdown runs until a transition is seen.
- R6: While `wd_in_valid` is 0, the timer is cleared after each clock edge and transitions on `wd_in` are ignored. After the valid input returns to 1, no countdown runs until a new transition is seen.
- R7: While `supply_ok` is 0, `wd_flag_n` is 0 in the same cycle, whatever the timer state.
- R8: When `supply_ok` returns to 1, `wd_flag_n` reflects the timer in the same cycle, with no minimum low time. The timer keeps its count and expiry time regardless of the supply.
- R9: A `wd_in` pulse one clock period wide is detected as activity. Its two transitions restart the countdown twice on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wd_in | input | 1 | Asynchronous heartbeat line from the processor |
| wd_in_valid | input | 1 | 1 when the heartbeat line is driven; 0 models a floating or tri-stated pin |
| sys_reset_active | input | 1 | 1 while the system reset is asserted |
| supply_ok | input | 1 | 1 while the supply is above its threshold |
| wd_flag_n | output | 1 | Active-low watchdog flag |

## Verification
The supply override is combinational, so the bench samples the flag one nanosecond after it changes `supply_ok`, inside the same cycle. A change on `wd_in` is first sampled at edge n. The bench expects the kick to take effect after edge n+2 and expiry after edge n+TIMEOUT_CYCLES+2. Its directed checks count falling clock edges from the drive point to land exactly on the cycles on each side of these boundaries. A behavioural model in the bench delays the input through a sample queue and counts cycles with integers. The model is compared with the flag 2 ns after every rising edge, while inputs are stable, so hold, restart and override cases are also checked cycle by cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    WD_IDLE    = 2'd0,
    WD_RUN     = 2'd1,
    WD_EXPIRED = 2'd2
  } wd_state_e;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = d;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/wdt_edge.sv
module wdt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic enable,
  output logic kick
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sample;
  end

  assign kick = enable & (sample ^ prev_q);
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 2000,
  localparam int unsigned CNT_W = cnt_width(TIMEOUT_CYCLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             kick,
  output wd_state_e        state,
  output logic [CNT_W-1:0] cnt,
  output logic             expired
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  wd_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (hold) begin
      state_d = WD_IDLE;
      cnt_d   = '0;
    end else if (kick) begin
      state_d = WD_RUN;
      cnt_d   = '0;
    end else if (state_q == WD_RUN) begin
      if (cnt_q == LAST) state_d = WD_EXPIRED;
      else               cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WD_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state   = state_q;
  assign cnt     = cnt_q;
  assign expired = (state_q == WD_EXPIRED);
endmodule

// File: rtl/edge_kick_wdt.sv
module edge_kick_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 2000,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_in,
  input  logic wd_in_valid,
  input  logic sys_reset_active,
  input  logic supply_ok,
  output logic wd_flag_n
);
  localparam int unsigned CNT_W = cnt_width(TIMEOUT_CYCLES);

  logic             sync_q;
  logic             kick;
  logic             hold;
  wd_state_e        tmr_state;
  logic [CNT_W-1:0] tmr_cnt;
  logic             expired;

  wdt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(wd_in), .q(sync_q)
  );

  wdt_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sample(sync_q), .enable(wd_in_valid), .kick(kick)
  );

  assign hold = sys_reset_active | ~wd_in_valid;

  wdt_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .hold(hold), .kick(kick),
    .state(tmr_state), .cnt(tmr_cnt), .expired(expired)
  );

  assign wd_flag_n = supply_ok & ~expired;
endmodule

// File: rtl/edge_kick_wdt_chk.sv
module edge_kick_wdt_chk
  import wdt_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 2000,
  localparam int unsigned CNT_W = cnt_width(TIMEOUT_CYCLES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sys_reset_active,
  input logic             wd_in_valid,
  input logic             supply_ok,
  input logic             wd_flag_n,
  input logic             kick,
  input logic             hold,
  input wd_state_e        state,
  input logic [CNT_W-1:0] cnt
);
  a_r1_idle_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WD_IDLE && !kick) |=> state == WD_IDLE);

  a_r2_kick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && !hold) |=> (state == WD_RUN && cnt == '0));

  a_r4_expiry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WD_EXPIRED && !kick && !hold) |=> state == WD_EXPIRED);

  a_r5_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_active |=> (state == WD_IDLE && cnt == '0));

  a_r6_float_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_in_valid |=> (state == WD_IDLE && cnt == '0));

  a_r7_supply_low_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> !wd_flag_n);

  a_r8_supply_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(supply_ok) && state != WD_EXPIRED) |-> wd_flag_n);
endmodule

bind edge_kick_wdt edge_kick_wdt_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_reset_active(sys_reset_active),
  .wd_in_valid(wd_in_valid), .supply_ok(supply_ok), .wd_flag_n(wd_flag_n),
  .kick(kick), .hold(hold), .state(tmr_state), .cnt(tmr_cnt)
);

// File: tb/tb_edge_kick_wdt.sv
`timescale 1ns/1ps
module tb_edge_kick_wdt;
  localparam int T = 40;

  logic clk = 1'b0;
  logic rst_n, wd_in, wd_in_valid, sys_reset_active, supply_ok;
  logic wd_flag_n;

  int checks = 0;
  int failures = 0;
  string phase = "R1";

  edge_kick_wdt #(.TIMEOUT_CYCLES(T), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .wd_in(wd_in), .wd_in_valid(wd_in_valid),
    .sys_reset_active(sys_reset_active), .supply_ok(supply_ok), .wd_flag_n(wd_flag_n)
  );

  always #4 clk = ~clk;

  // behavioural reference: sample queue plus integer timer
  bit m_q[$];
  bit m_prev;
  int m_mode;  // 0 idle, 1 counting, 2 expired
  int m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q = {1'b0, 1'b0};
      m_prev = 1'b0; m_mode = 0; m_cnt = 0;
    end else begin
      bit seen;
      bit cur;
      cur = m_q[1];
      seen = wd_in_valid && (cur != m_prev);
      if (sys_reset_active || !wd_in_valid) begin
        m_mode = 0; m_cnt = 0;
      end else if (seen) begin
        m_mode = 1; m_cnt = 0;
      end else if (m_mode == 1) begin
        if (m_cnt == T - 1) m_mode = 2;
        else m_cnt++;
      end
      m_prev = cur;
      m_q.push_front(wd_in);
      void'(m_q.pop_back());
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      logic exp_v;
      exp_v = supply_ok && (m_mode != 2);
      checks++;
      if (wd_flag_n !== exp_v) begin
        failures++;
        $display("FAIL %s per-cycle model: wd_flag_n=%0b expected=%0b at %0t",
                 phase, wd_flag_n, exp_v, $time);
      end
    end
  end

  task automatic check(input string tag, input logic exp_v);
    checks++;
    if (wd_flag_n !== exp_v) begin
      failures++;
      $display("FAIL %s: wd_flag_n=%0b expected=%0b at %0t", tag, wd_flag_n, exp_v, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog: run did not finish, flag=%0b expected=done", wd_flag_n);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wd_in = 1'b0; wd_in_valid = 1'b1;
    sys_reset_active = 1'b0; supply_ok = 1'b1;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check("R1 reset state", 1'b1);
    tick(3 * T);
    check("R1 no expiry without transition", 1'b1);

    phase = "R2";
    wd_in = 1'b1;
    tick(T + 2); check("R2 one cycle before expiry", 1'b1);
    tick(1);     check("R2 expiry cycle", 1'b0);

    phase = "R4";
    tick(T);     check("R4 expiry sticky", 1'b0);
    wd_in = 1'b0;
    tick(2);     check("R4 still low before kick lands", 1'b0);
    tick(1);     check("R4 kick releases flag", 1'b1);

    phase = "R3";
    for (int i = 0; i < 6; i++) begin
      tick(T / 2);
      wd_in = ~wd_in;
    end
    check("R3 periodic kicks keep flag high", 1'b1);
    tick(T + 2); check("R3 full countdown after last kick", 1'b1);
    tick(1);     check("R3 expiry after last kick", 1'b0);

    phase = "R5";
    wd_in = ~wd_in;
    tick(5);
    sys_reset_active = 1'b1;
    tick(T + 5);
    for (int i = 0; i < 4; i++) begin wd_in = ~wd_in; tick(3); end
    tick(4);
    check("R5 held clear during reset", 1'b1);
    sys_reset_active = 1'b0;
    tick(2 * T);
    check("R5 no countdown after release without kick", 1'b1);
    wd_in = ~wd_in;
    tick(T + 3);
    check("R5 countdown after kick following release", 1'b0);

    phase = "R6";
    wd_in_valid = 1'b0;
    tick(1);     check("R6 floating clears expired timer", 1'b1);
    for (int i = 0; i < 4; i++) begin wd_in = ~wd_in; tick(3); end
    tick(T);     check("R6 transitions ignored while floating", 1'b1);
    wd_in_valid = 1'b1;
    tick(2 * T); check("R6 no countdown after valid returns", 1'b1);

    phase = "R7";
    wd_in = ~wd_in;
    tick(10);
    supply_ok = 1'b0;
    #1 check("R7 supply low forces flag low same cycle", 1'b0);
    tick(5);
    phase = "R8";
    supply_ok = 1'b1;
    #1 check("R8 supply release immediate", 1'b1);
    // kick sampled at n; 10+5 ticks elapsed; expiry after n+T+2 unchanged
    tick(T + 3 - 15 - 1); check("R8 timer unaffected, before expiry", 1'b1);
    tick(1);              check("R8 timer unaffected, expiry", 1'b0);
    supply_ok = 1'b0;
    tick(3);
    supply_ok = 1'b1;
    #1 check("R8 expired timer still low after supply returns", 1'b0);

    phase = "R9";
    wd_in = ~wd_in;
    tick(1);
    wd_in = ~wd_in;
    tick(2);     check("R9 short pulse releases flag", 1'b1);
    tick(T);     check("R9 second transition restarted count", 1'b1);
    tick(1);     check("R9 expiry after second transition", 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule